// File: doc/BRIEF.md
# Luma/Chroma Gain Offset Processor

This block scales and offsets a component video stream, one sample per clock. An unsigned 8-bit luma sample is multiplied by a contrast gain and then shifted by a signed brightness offset. Each of the two signed colour-difference samples (blue minus luma and red minus luma) is multiplied by its own saturation gain. Every result is brought back to 8 bits and clipped. The multiplications keep their full precision. The return to 8 bits uses plain rounding or one of two error-diffusion modes. Error diffusion carries the discarded fraction of one sample into the next sample on the same channel. This breaks up the contouring that appears when a gain is close to a simple ratio.

The colour-difference path has two modes. In the direct mode the gains act on the raw differences, so software sets the whole scaling through the two gain codes. In the prescaled mode the blue difference is first halved and the red difference is multiplied by seven eighths. These fixed factors are the usual weightings for composite-style colour difference signals, and they are applied before the gains. The gains then only trim saturation. A bypass input passes the samples through unchanged with the same latency as the processed path. All results appear one clock after the sample is strobed in.

Top module: `ygo_gain_offset`

## Requirements
- R1: With quant_sel 00 or 11 (rounding), out_y equals in_y*contrast/32 + brightness, rounded by adding one half LSB and rounding down.
- R2: brightness is a two's complement offset from -128 to +127. It is added in whole output LSBs after the contrast product.
- R3: With pal_prescale low, out_u equals (in_bmy*sat_u)/32 and out_v equals (in_rmy*sat_v)/32, requantised like luma. All chroma values are two's complement.
- R4: With pal_prescale high, in_bmy is scaled by exactly 1/2 and in_rmy by exactly 7/8 (x - x/8, with no intermediate rounding), before the saturation gain.
- R5: out_y is clipped to 0..255. out_u and out_v are clipped to -128..+127.
- R6: With quant_sel 01, each channel adds its stored 1-bit residue (weight 1/2 LSB) to the exact value and truncates toward minus infinity. It then stores the first fraction bit of that sum as the new residue.
- R7: With quant_sel 10, each channel adds its stored 2-bit residue (weight 1/4 LSB per unit) and truncates toward minus infinity. It then stores the top two fraction bits of that sum as the new residue.
- R8: A cycle with in_valid low or enable low clears the residues of all three channels to zero.
- R9: With enable low, a valid sample leaves the block unchanged on out_y, out_u and out_v after one clock.
- R10: out_valid is in_valid delayed by one clock. While in_valid is low the data outputs hold their last values.
- R11: During reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | 1 = processing, 0 = bypass |
| in_valid | input | 1 | Sample strobe |
| in_y | input | 8 | Luma, unsigned |
| in_bmy | input | 8 | Blue difference, two's complement |
| in_rmy | input | 8 | Red difference, two's complement |
| contrast | input | 6 | Luma gain code, value/32 |
| brightness | input | 8 | Luma offset, two's complement |
| sat_u | input | 6 | Blue-difference gain code, value/32 |
| sat_v | input | 6 | Red-difference gain code, value/32 |
| pal_prescale | input | 1 | 1 = apply the fixed 1/2 and 7/8 prescale |
| quant_sel | input | 2 | 00/11 round, 01 one-bit diffusion, 10 two-bit diffusion |
| out_valid | output | 1 | Output strobe |
| out_y | output | 8 | Processed luma |
| out_u | output | 8 | Processed blue difference |
| out_v | output | 8 | Processed red difference |

## Verification
The rounding paths are swept over every contrast code, with luma values spread across the full range and with offsets at both extremes and in between. This separates the product, the offset sign and the clip at both rails. The chroma sweeps run every gain code against the whole signed input range, once in each prescale mode. The 7/8 factor differs from 1/2 and from 1, so a wrong shift or a lost fraction bit shows up. Long streams that vary the inputs, run in both diffusion modes, show whether the residue is carried, how many bits it holds, and whether it is cleared by a gap in the strobe or by a bypass cycle. Bypass samples and strobe-low cycles confirm the pass-through and hold behaviour.

// File: rtl/ygo_pkg.sv
package ygo_pkg;
   typedef enum logic [1:0] {
      QM_ROUND  = 2'b00,
      QM_DIFF1  = 2'b01,
      QM_DIFF2  = 2'b10,
      QM_ROUND2 = 2'b11
   } quant_mode_e;
endpackage

// File: rtl/ygo_prescale.sv
// Fixed colour-difference prescale, exact in PF fraction bits.
module ygo_prescale #(
   parameter int DW            = 8,
   parameter int PF            = 3,
   parameter bit SEVEN_EIGHTHS = 1'b0
) (
   input  logic                     internal,
   input  logic signed [DW-1:0]     x,
   output logic signed [DW+PF-1:0]  y
);
   localparam int OW = DW + PF;

   logic signed [OW-1:0] x_w;
   logic signed [OW-1:0] direct;
   logic signed [OW-1:0] scaled;

   generate
      if (PF < 3) begin : g_bad_pf
         $error("ygo_prescale: PF must be at least 3 for an exact 7/8 factor");
      end
   endgenerate

   assign x_w    = OW'(x);
   assign direct = x_w <<< PF;

   generate
      if (SEVEN_EIGHTHS) begin : g_seven_eighths
         // x - x/8, exact in PF fraction bits
         assign scaled = direct - (x_w <<< (PF - 3));
      end else begin : g_half
         assign scaled = x_w <<< (PF - 1);
      end
   endgenerate

   assign y = internal ? scaled : direct;
endmodule

// File: rtl/ygo_requant.sv
// Requantise a fixed-point value to OW bits: rounding or error diffusion, then clip.
module ygo_requant
   import ygo_pkg::*;
#(
   parameter int IW         = 16,
   parameter int FRAC       = 5,
   parameter int OW         = 8,
   parameter bit SIGNED_OUT = 1'b0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  advance,
   input  quant_mode_e           mode,
   input  logic signed [IW-1:0]  din,
   output logic [OW-1:0]         dout
);
   localparam int RW   = IW + 1;
   localparam int HI_I = SIGNED_OUT ? (2 ** (OW - 1)) - 1 : (2 ** OW) - 1;
   localparam int LO_I = SIGNED_OUT ? -(2 ** (OW - 1)) : 0;
   localparam logic signed [RW-1:0] HI_V = RW'(HI_I);
   localparam logic signed [RW-1:0] LO_V = RW'(LO_I);

   generate
      if (FRAC < 2) begin : g_bad_frac
         $error("ygo_requant: FRAC must be at least 2");
      end
      if (IW <= OW) begin : g_bad_iw
         $error("ygo_requant: IW must exceed OW");
      end
   endgenerate

   logic [1:0]           res_q;
   logic [1:0]           res_d;
   logic                 diffuse;
   logic signed [RW-1:0] din_x;
   logic signed [RW-1:0] bias;
   logic signed [RW-1:0] sum;
   logic signed [RW-1:0] q;

   always_comb begin
      diffuse = (mode == QM_DIFF1) || (mode == QM_DIFF2);
      din_x   = RW'(din);
      bias    = '0;
      if (diffuse) begin
         bias[FRAC-1 -: 2] = res_q;   // residue counted in quarter LSBs
      end else begin
         bias[FRAC-1] = 1'b1;         // one half LSB
      end
      sum = din_x + bias;
      q   = sum >>> FRAC;
      case (mode)
         QM_DIFF2: res_d = sum[FRAC-1 -: 2];
         QM_DIFF1: res_d = {sum[FRAC-1], 1'b0};
         default:  res_d = 2'b00;
      endcase
   end

   generate
      if (SIGNED_OUT) begin : g_sclip
         always_comb begin
            if (q > HI_V)      dout = HI_V[OW-1:0];
            else if (q < LO_V) dout = LO_V[OW-1:0];
            else               dout = q[OW-1:0];
         end
      end else begin : g_uclip
         always_comb begin
            if (q > HI_V)      dout = HI_V[OW-1:0];
            else if (q < LO_V) dout = '0;
            else               dout = q[OW-1:0];
         end
         // R5: any negative exact value lands on the lower rail
         assert_neg_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
            din[IW-1] |-> (dout == '0));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_q <= 2'b00;
      end else if (advance) begin
         res_q <= res_d;
      end else begin
         res_q <= 2'b00;              // R8
      end
   end
endmodule

// File: rtl/ygo_gain_offset.sv
module ygo_gain_offset
   import ygo_pkg::*;
#(
   parameter int DW    = 8,
   parameter int GW    = 6,
   parameter int GFRAC = 5,
   parameter int PF    = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           enable,
   input  logic           in_valid,
   input  logic [DW-1:0]  in_y,
   input  logic [DW-1:0]  in_bmy,
   input  logic [DW-1:0]  in_rmy,
   input  logic [GW-1:0]  contrast,
   input  logic [DW-1:0]  brightness,
   input  logic [GW-1:0]  sat_u,
   input  logic [GW-1:0]  sat_v,
   input  logic           pal_prescale,
   input  logic [1:0]     quant_sel,
   output logic           out_valid,
   output logic [DW-1:0]  out_y,
   output logic [DW-1:0]  out_u,
   output logic [DW-1:0]  out_v
);
   localparam int LW = DW + GW + 2;        // luma exact value
   localparam int SW = DW + PF;            // prescaled chroma
   localparam int CW = DW + PF + GW + 1;   // chroma exact value
   localparam int CFRAC = GFRAC + PF;

   generate
      if (GFRAC < 2 || GFRAC > GW) begin : g_bad_gfrac
         $error("ygo_gain_offset: GFRAC must lie in 2..GW");
      end
   endgenerate

   quant_mode_e qm;
   logic        advance;
   assign qm      = quant_mode_e'(quant_sel);
   assign advance = in_valid & enable;

   // ---------------- luma: Y*ct + br ----------------
   logic signed [LW-1:0] y_ext, ct_ext, br_ext, luma_full;
   assign y_ext     = LW'($signed({1'b0, in_y}));
   assign ct_ext    = LW'($signed({1'b0, contrast}));
   assign br_ext    = LW'($signed(brightness));
   assign luma_full = (y_ext * ct_ext) + (br_ext <<< GFRAC);

   // ---------------- chroma: prescale then gain ----------------
   logic signed [SW-1:0] u_pre, v_pre;
   logic signed [CW-1:0] u_full, v_full, su_ext, sv_ext;

   ygo_prescale #(.DW(DW), .PF(PF), .SEVEN_EIGHTHS(1'b0)) i_pre_u (
      .internal(pal_prescale), .x($signed(in_bmy)), .y(u_pre));
   ygo_prescale #(.DW(DW), .PF(PF), .SEVEN_EIGHTHS(1'b1)) i_pre_v (
      .internal(pal_prescale), .x($signed(in_rmy)), .y(v_pre));

   assign su_ext = CW'($signed({1'b0, sat_u}));
   assign sv_ext = CW'($signed({1'b0, sat_v}));
   assign u_full = CW'(u_pre) * su_ext;
   assign v_full = CW'(v_pre) * sv_ext;

   // ---------------- requantisation ----------------
   logic [DW-1:0] y_q, u_q, v_q;

   ygo_requant #(.IW(LW), .FRAC(GFRAC), .OW(DW), .SIGNED_OUT(1'b0)) i_rq_y (
      .clk(clk), .rst_n(rst_n), .advance(advance), .mode(qm), .din(luma_full), .dout(y_q));
   ygo_requant #(.IW(CW), .FRAC(CFRAC), .OW(DW), .SIGNED_OUT(1'b1)) i_rq_u (
      .clk(clk), .rst_n(rst_n), .advance(advance), .mode(qm), .din(u_full), .dout(u_q));
   ygo_requant #(.IW(CW), .FRAC(CFRAC), .OW(DW), .SIGNED_OUT(1'b1)) i_rq_v (
      .clk(clk), .rst_n(rst_n), .advance(advance), .mode(qm), .din(v_full), .dout(v_q));

   // ---------------- output stage ----------------
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_y     <= '0;
         out_u     <= '0;
         out_v     <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            if (enable) begin
               out_y <= y_q;
               out_u <= u_q;
               out_v <= v_q;
            end else begin
               out_y <= in_y;
               out_u <= in_bmy;
               out_v <= in_rmy;
            end
         end
      end
   end

   // ---------------- assertions ----------------
   assert_zero_gain_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && in_valid && contrast == '0 && !brightness[DW-1])
      |=> (out_y == $past(brightness)));

   assert_zero_sat_u_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && in_valid && sat_u == '0) |=> (out_u == '0));

   assert_zero_sat_v_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && in_valid && sat_v == '0) |=> (out_v == '0));

   assert_bypass_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!enable && in_valid) |=> (out_y == $past(in_y) && out_u == $past(in_bmy)
                                 && out_v == $past(in_rmy)));

   assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(out_y) && $stable(out_u) && $stable(out_v) && !out_valid));
endmodule

// File: tb/test_ygo_gain_offset.sv
`timescale 1ns/1ps
module test_ygo_gain_offset;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       enable = 1'b1;
   logic       in_valid = 1'b0;
   logic [7:0] in_y = '0, in_bmy = '0, in_rmy = '0, brightness = '0;
   logic [5:0] contrast = '0, sat_u = '0, sat_v = '0;
   logic       pal_prescale = 1'b0;
   logic [1:0] quant_sel = 2'b00;
   logic       out_valid;
   logic [7:0] out_y, out_u, out_v;

   int checks = 0;
   int errors = 0;
   string cur_req = "R11";
   int exp_y = 0, exp_u = 0, exp_v = 0;
   int res_y = 0, res_u = 0, res_v = 0;

   always #2.5 clk = ~clk;

   ygo_gain_offset i_ygo_gain_offset (
      .clk(clk), .rst_n(rst_n), .enable(enable), .in_valid(in_valid),
      .in_y(in_y), .in_bmy(in_bmy), .in_rmy(in_rmy), .contrast(contrast),
      .brightness(brightness), .sat_u(sat_u), .sat_v(sat_v),
      .pal_prescale(pal_prescale), .quant_sel(quant_sel),
      .out_valid(out_valid), .out_y(out_y), .out_u(out_u), .out_v(out_v));

   task automatic chk(input string what, input int act, input int expv);
      checks++;
      if (act != expv) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", cur_req, what, act, expv);
      end
   endtask

   // requantise per R1/R6/R7, clip per R5
   function automatic int rq(input int val, input int frac, input int mode,
                             input int res_in, input bit sgn, output int res_out);
      int sum, q, hi, lo;
      if (mode == 1 || mode == 2) sum = val + (res_in << (frac - 2));
      else                        sum = val + (1 << (frac - 1));
      q = sum >>> frac;
      if (mode == 2)      res_out = (sum >>> (frac - 2)) & 3;
      else if (mode == 1) res_out = ((sum >>> (frac - 1)) & 1) * 2;
      else                res_out = 0;
      hi = sgn ? 127 : 255;
      lo = sgn ? -128 : 0;
      if (q > hi) q = hi;
      if (q < lo) q = lo;
      return q;
   endfunction

   task automatic apply(input bit v, input bit e, input int y, input int bmy, input int rmy);
      int su, sv, br, ny, nu, nv;
      @(negedge clk);
      in_valid = v; enable = e;
      in_y = 8'(y); in_bmy = 8'(bmy); in_rmy = 8'(rmy);
      if (v && e) begin
         br = $signed(brightness);
         su = pal_prescale ? bmy * 4 : bmy * 8;
         sv = pal_prescale ? rmy * 8 - rmy : rmy * 8;
         exp_y = rq(y * int'(contrast) + br * 32, 5, int'(quant_sel), res_y, 1'b0, ny);
         exp_u = rq(su * int'(sat_u), 8, int'(quant_sel), res_u, 1'b1, nu);
         exp_v = rq(sv * int'(sat_v), 8, int'(quant_sel), res_v, 1'b1, nv);
         res_y = ny; res_u = nu; res_v = nv;
      end else begin
         if (v) begin exp_y = y; exp_u = bmy; exp_v = rmy; end
         res_y = 0; res_u = 0; res_v = 0;
      end
      @(posedge clk);
      #1;
      chk("out_valid", int'(out_valid), int'(v));
      chk("out_y", int'(out_y), exp_y);
      chk("out_u", int'($signed(out_u)), exp_u);
      chk("out_v", int'($signed(out_v)), exp_v);
   endtask

   task automatic stream(input int n, input int gap_at, input bit bypass_at_gap);
      for (int i = 0; i < n; i++) begin
         if (i == gap_at) apply(bypass_at_gap, 1'b0 == bypass_at_gap ? 1'b1 : 1'b0, 77, -9, 14);
         apply(1'b1, 1'b1, (i * 37 + 11) % 256, ((i * 53 + 7) % 256) - 128,
               ((i * 29 + 100) % 256) - 128);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int brs[4];
      brs = '{-128, -37, 0, 127};
      // R11: reset state
      repeat (3) @(posedge clk);
      #1;
      cur_req = "R11";
      chk("out_valid", int'(out_valid), 0);
      chk("out_y", int'(out_y), 0);
      chk("out_u", int'(out_u), 0);
      chk("out_v", int'(out_v), 0);
      @(negedge clk);
      rst_n = 1'b1;

      // R1, R2, R5: luma sweep with rounding
      cur_req = "R1/R2/R5";
      quant_sel = 2'b00; pal_prescale = 1'b0; sat_u = 6'd32; sat_v = 6'd32;
      foreach (brs[b]) begin
         brightness = 8'(brs[b]);
         for (int ct = 0; ct < 64; ct++) begin
            contrast = 6'(ct);
            for (int y = 0; y <= 260; y += 5) apply(1'b1, 1'b1, (y > 255) ? 255 : y, 0, 0);
         end
      end

      // R3, R5: direct chroma sweep; R4: prescaled chroma sweep
      contrast = 6'd32; brightness = 8'd0;
      for (int m = 0; m < 2; m++) begin
         pal_prescale = m[0];
         cur_req = m ? "R4" : "R3/R5";
         for (int s = 0; s < 64; s++) begin
            sat_u = 6'(s); sat_v = 6'(63 - s);
            for (int x = -128; x <= 129; x += 3) begin
               apply(1'b1, 1'b1, 100, (x > 127) ? 127 : x, (x > 127) ? -128 : -x - 1);
            end
         end
      end

      // R1: code 11 also rounds
      cur_req = "R1";
      quant_sel = 2'b11; pal_prescale = 1'b1; sat_u = 6'd41; sat_v = 6'd19;
      contrast = 6'd45; brightness = 8'(-3);
      for (int i = 0; i < 64; i++) apply(1'b1, 1'b1, i * 4, i * 4 - 128, 127 - i * 4);

      // R6: one-bit diffusion stream
      cur_req = "R6";
      quant_sel = 2'b01; pal_prescale = 1'b0;
      contrast = 6'd37; brightness = 8'(-5); sat_u = 6'd45; sat_v = 6'd23;
      apply(1'b0, 1'b1, 0, 0, 0);
      stream(150, -1, 1'b0);

      // R7: two-bit diffusion stream
      cur_req = "R7";
      quant_sel = 2'b10; pal_prescale = 1'b1;
      contrast = 6'd27; brightness = 8'(9); sat_u = 6'd51; sat_v = 6'd35;
      apply(1'b0, 1'b1, 0, 0, 0);
      stream(150, -1, 1'b0);

      // R8 and R10: strobe gap clears residue, outputs hold
      cur_req = "R8/R10";
      stream(120, 60, 1'b0);

      // R8 and R9: bypass sample passes through and clears residue
      cur_req = "R8/R9";
      stream(120, 45, 1'b1);
      cur_req = "R9";
      for (int i = 0; i < 16; i++) apply(1'b1, 1'b0, i * 16, -128 + i * 17, 127 - i * 13);

      // R10: strobe low holds the last values
      cur_req = "R10";
      apply(1'b1, 1'b1, 200, 50, -60);
      apply(1'b0, 1'b1, 3, 4, 5);
      apply(1'b0, 1'b0, 9, 8, 7);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule